// File: doc/BRIEF.md
# Transfer Unit Valid-Slot Moderator

This block produces the per-cycle slot pattern for fixed-length transfer units on a serial display main link. Each transfer unit has between 32 and 64 symbol slots. The block marks a programmed number of leading slots in each unit as payload and the rest as filler. The pattern is the same on every lane. When boundary moderation is on, the payload count switches between an upper value and a lower value (one less) in programmed run lengths. Over a line, the average payload per unit then matches a fractional target that no single integer count can reach.

The block has three configuration words and a one-cycle line-start strobe. After the strobe, the block holds a gate closed for a programmed number of link clock cycles. It then opens the gate and steps through slots one per cycle until the next strobe. Computing the parameters and encoding the symbols are left to other logic.

Top module: `tu_moderator`

## Requirements
- R1: The transfer unit length in slots is `cfg_unit[5:0] + 1`. Legal field values are 31 to 63. The slot position wraps to 0 after the last slot of a unit.
- R2: In `cfg_bound`, bits [6:0] hold the upper payload count and bits [31:16] hold the start delay in link clock cycles.
- R3: In `cfg_moderate`, bit 0 enables moderation, bits [7:1] hold the lower payload count, bits [19:16] hold the upper run length and bits [23:20] hold the lower run length. Each run length is 1 to 15.
- R4: Within each unit, slots 0 to count-1 are payload (`lane_valid` high) and the remaining slots are filler (`lane_valid` low).
- R5: With moderation enabled, the block sends the upper-run number of units with the upper count, then the lower-run number of units with the lower count, and repeats this cycle for the rest of the line.
- R6: With moderation disabled, every unit uses the upper payload count and the run-length fields have no effect.
- R7: If a line-start strobe is sampled at a clock edge, `link_gate` rises D cycles after that edge, where D is the start delay. With D = 0 it is high in the cycle right after that edge. Until `link_gate` rises, both `link_gate` and `lane_valid` are low. Once open, `link_gate` stays high until the next strobe.
- R8: A line-start strobe at any point (mid-unit, mid-run or during the delay) restarts the sequence at slot 0 of the first upper-run unit and reloads the delay.
- R9: After reset, `link_gate` and `lane_valid` stay low until the first line-start strobe.
- R10: All lanes of `lane_valid` carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unit | input | 32 | Unit length minus one in [5:0] |
| cfg_bound | input | 32 | Upper payload count [6:0], start delay [31:16] |
| cfg_moderate | input | 32 | Enable [0], lower count [7:1], upper run [19:16], lower run [23:20] |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| link_gate | output | 1 | High once the start delay has elapsed |
| lane_valid | output | LANES | Per-lane payload (1) / filler (0) indication |

## Verification
The bench compares every cycle of each line against a model that computes the unit, slot and run phase from the cycle offset.

- Unit and run boundaries: a design that wraps one slot early or late, or that switches runs at the wrong unit, would shift the whole pattern off its expected place.
- Delay of zero: a wrong design would open the gate one cycle late.
- A payload count equal to the unit length: a wrong design would leave a spurious filler slot.
- A lower count of zero: a wrong design would let payload through in lower-run units.
- Moderation disabled with non-zero run fields: a design that still reads the run fields would produce short units.
- A new strobe in the middle of a lower run: a design that keeps stale run state would continue the old run instead of starting with upper-count units.

// File: rtl/tu_mod_pkg.sv
package tu_mod_pkg;
  localparam int CNT_W = 7;   // slot counts up to 64
  localparam int RUN_W = 4;   // run lengths 1..15
  localparam int DLY_W = 16;  // start delay
  localparam int SZ_W  = 6;   // unit length minus one field

  // field positions inside the configuration words
  localparam int UCNT_LSB = 0;
  localparam int DLY_LSB  = 16;
  localparam int EN_BIT   = 0;
  localparam int LCNT_LSB = 1;
  localparam int URUN_LSB = 16;
  localparam int LRUN_LSB = 20;

  typedef struct packed {
    logic [CNT_W-1:0] unit_m1;
    logic [CNT_W-1:0] upper_cnt;
    logic [CNT_W-1:0] lower_cnt;
    logic             mod_en;
    logic [RUN_W-1:0] upper_run;
    logic [RUN_W-1:0] lower_run;
    logic [DLY_W-1:0] start_dly;
  } tu_cfg_t;
endpackage

// File: rtl/tu_cfg_decode.sv
module tu_cfg_decode
  import tu_mod_pkg::*;
(
  input  logic [31:0] cfg_unit,
  input  logic [31:0] cfg_bound,
  input  logic [31:0] cfg_moderate,
  output tu_cfg_t     cfg
);
  always_comb begin
    cfg.unit_m1   = {{(CNT_W-SZ_W){1'b0}}, cfg_unit[SZ_W-1:0]};
    cfg.upper_cnt = cfg_bound[UCNT_LSB +: CNT_W];
    cfg.start_dly = cfg_bound[DLY_LSB +: DLY_W];
    cfg.mod_en    = cfg_moderate[EN_BIT];
    cfg.lower_cnt = cfg_moderate[LCNT_LSB +: CNT_W];
    cfg.upper_run = cfg_moderate[URUN_LSB +: RUN_W];
    cfg.lower_run = cfg_moderate[LRUN_LSB +: RUN_W];
  end
endmodule

// File: rtl/tu_start_gate.sv
module tu_start_gate
  import tu_mod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [DLY_W-1:0] start_dly,
  output logic             gate_open
);
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             dly_en;

  always_comb begin
    armed_d = armed_q;
    dly_d   = dly_q;
    dly_en  = 1'b0;
    if (line_start) begin
      armed_d = 1'b1;
      dly_d   = start_dly;
      dly_en  = 1'b1;
    end else if (armed_q && (dly_q != '0)) begin
      dly_d  = dly_q - 1'b1;
      dly_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (dly_en) dly_q <= dly_d;
    end
  end

  assign gate_open = armed_q && (dly_q == '0);
endmodule

// File: rtl/tu_slot_seq.sv
module tu_slot_seq
  import tu_mod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  tu_cfg_t          cfg,
  output logic [CNT_W-1:0] slot_idx,
  output logic             slot_valid
);
  logic [CNT_W-1:0] slot_q, slot_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             lo_q, lo_d;
  logic             st_en;
  logic             unit_end;
  logic [CNT_W-1:0] cur_cnt;

  assign unit_end = (slot_q == cfg.unit_m1);
  assign cur_cnt  = lo_q ? cfg.lower_cnt : cfg.upper_cnt;

  always_comb begin
    slot_d = slot_q;
    run_d  = run_q;
    lo_d   = lo_q;
    st_en  = restart || advance;
    if (restart) begin
      slot_d = '0;
      run_d  = '0;
      lo_d   = 1'b0;
    end else if (advance) begin
      if (unit_end) begin
        slot_d = '0;
        if (cfg.mod_en) begin
          if (!lo_q) begin
            if (run_q == cfg.upper_run - 1'b1) begin
              lo_d  = 1'b1;
              run_d = '0;
            end else begin
              run_d = run_q + 1'b1;
            end
          end else begin
            if (run_q == cfg.lower_run - 1'b1) begin
              lo_d  = 1'b0;
              run_d = '0;
            end else begin
              run_d = run_q + 1'b1;
            end
          end
        end
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      run_q  <= '0;
      lo_q   <= 1'b0;
    end else if (st_en) begin
      slot_q <= slot_d;
      run_q  <= run_d;
      lo_q   <= lo_d;
    end
  end

  assign slot_idx   = slot_q;
  assign slot_valid = advance && (slot_q < cur_cnt);
endmodule

// File: rtl/tu_moderator.sv
module tu_moderator
  import tu_mod_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_unit,
  input  logic [31:0]      cfg_bound,
  input  logic [31:0]      cfg_moderate,
  input  logic             line_start,
  output logic             link_gate,
  output logic [LANES-1:0] lane_valid
);
  tu_cfg_t          cfg;
  logic             gate_open;
  logic             slot_valid;
  logic [CNT_W-1:0] slot_idx;

  tu_cfg_decode u_dec (
    .cfg_unit     (cfg_unit),
    .cfg_bound    (cfg_bound),
    .cfg_moderate (cfg_moderate),
    .cfg          (cfg)
  );

  tu_start_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .start_dly  (cfg.start_dly),
    .gate_open  (gate_open)
  );

  tu_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (line_start),
    .advance    (gate_open),
    .cfg        (cfg),
    .slot_idx   (slot_idx),
    .slot_valid (slot_valid)
  );

  assign link_gate = gate_open;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_valid[g] = slot_valid;
  end
endmodule

// File: rtl/tu_moderator_chk.sv
module tu_moderator_chk
  import tu_mod_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             link_gate,
  input logic [LANES-1:0] lane_valid,
  input logic [CNT_W-1:0] slot_idx,
  input logic [CNT_W-1:0] unit_m1,
  input logic [DLY_W-1:0] start_dly
);
  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= unit_m1);

  assert_filler_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_gate && lane_valid == '0 && slot_idx != unit_m1 && !line_start)
      |=> (lane_valid == '0));

  assert_gate_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && start_dly != '0) |=> !link_gate);

  assert_valid_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0) |-> link_gate);

  assert_gate_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_gate && !line_start) |=> link_gate);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (slot_idx == '0));

  assert_lanes_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_valid) == 0) || ($countones(lane_valid) == LANES));
endmodule

bind tu_moderator tu_moderator_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .link_gate  (link_gate),
  .lane_valid (lane_valid),
  .slot_idx   (slot_idx),
  .unit_m1    (cfg.unit_m1),
  .start_dly  (cfg.start_dly)
);

// File: tb/test_tu_moderator.sv
`timescale 1ns/1ps
module test_tu_moderator;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [31:0]      cfg_unit, cfg_bound, cfg_moderate;
  logic             line_start;
  logic             link_gate;
  logic [LANES-1:0] lane_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tu_moderator #(.LANES(LANES)) i_tu_moderator (
    .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_bound(cfg_bound),
    .cfg_moderate(cfg_moderate), .line_start(line_start),
    .link_gate(link_gate), .lane_valid(lane_valid)
  );

  // expected payload bit at cycle k after the strobe-sampling edge
  function automatic bit exp_valid(int k, int size, int d, int ucnt, int lcnt,
                                   bit en, int ur, int lr);
    int j, u, s, c;
    if (k < d) return 0;
    j = k - d;
    u = j / size;
    s = j % size;
    c = ucnt;
    if (en && ((u % (ur + lr)) >= ur)) c = lcnt;
    return s < c;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one line for n cycles; req names the requirement exercised
  task automatic run_line(string req, int size, int d, int ucnt, int lcnt,
                          bit en, int ur, int lr, int n);
    cfg_unit     = size - 1;
    cfg_bound    = (d << 16) | ucnt;
    cfg_moderate = (lr << 20) | (ur << 16) | (lcnt << 1) | en;
    line_start   = 1'b1;
    @(negedge clk);
    line_start   = 1'b0;
    for (int k = 0; k < n; k++) begin
      bit ev;
      ev = exp_valid(k, size, d, ucnt, lcnt, en, ur, lr);
      check({req, " R7 gate"}, link_gate, (k >= d) ? 1 : 0);
      check({req, " R4 R10 lanes"}, lane_valid, ev ? ((1 << LANES) - 1) : 0);
      if (k != n - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    rst_n = 1'b0; line_start = 1'b0;
    cfg_unit = 0; cfg_bound = 0; cfg_moderate = 0;
    repeat (3) @(negedge clk);
    check("R9 reset gate", link_gate, 0);
    check("R9 reset lanes", lane_valid, 0);
    rst_n = 1'b1;
    // configuration present but no strobe yet
    cfg_unit = 31; cfg_bound = 20; cfg_moderate = 0;
    repeat (10) @(negedge clk);
    check("R9 idle gate", link_gate, 0);
    check("R9 idle lanes", lane_valid, 0);

    // directed corners
    run_line("R1 R2 zero delay", 32, 0, 20, 19, 0, 3, 2, 100);
    run_line("R6 runs ignored", 48, 5, 30, 0, 0, 1, 1, 300);
    run_line("R4 full unit", 64, 3, 64, 63, 1, 2, 1, 400);
    run_line("R3 lower zero", 33, 7, 1, 0, 1, 1, 15, 600);
    run_line("R5 moderated", 40, 10, 27, 26, 1, 3, 5, 40 * 16 + 20);
    // R8: cut mid lower run, then restart with new settings
    run_line("R5 partial", 36, 2, 20, 19, 1, 2, 4, 36 * 4 + 11);
    run_line("R8 restart mid run", 36, 4, 25, 24, 1, 2, 3, 36 * 10 + 6);
    // R8: cut during the delay, then restart
    run_line("R8 partial delay", 32, 30, 10, 9, 1, 1, 1, 12);
    run_line("R8 restart in delay", 50, 1, 49, 48, 1, 15, 15, 50 * 32);

    // constrained random lines
    for (int i = 0; i < 16; i++) begin
      int size, d, uc, ur, lr;
      bit en;
      size = 32 + ($urandom % 33);
      uc   = 1 + ($urandom % size);
      d    = $urandom % 40;
      ur   = 1 + ($urandom % 15);
      lr   = 1 + ($urandom % 15);
      en   = $urandom % 2;
      run_line("R5 R6 random", size, d, uc, uc - 1, en, ur, lr,
               d + size * (ur + lr) * 2 + 3);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule